// File: doc/BRIEF.md
# Dual-Address Control Register Bank

This block holds the control registers of a small sensor-style device. Two byte-level host paths reach them. The first is a two-wire, I2C-style path, which must first claim the device with an 8-bit device-address byte. The second is a four-wire, SPI-style path, which needs no device selection. The serial engines are not part of this block. They hand over whole bytes as one-cycle strobes.

The device answers to two device addresses at the same time. One address is fixed at 0xEA and cannot be changed. The other is held in a register that starts at 0xEA and can be rewritten from either path. Both paths share one register array:
- The two-wire map uses register addresses with bit 7 set.
- The four-wire map uses the same addresses with bit 7 cleared.

Any write to the data-less clear register wipes every control register in one cycle. The programmable device address is kept.

Bits [2:0] of the first control register form a test-select code. This code decides whether the two test pins are outputs carrying one of five internal signal pairs, or inputs.

Top module: `ctrlbank_top`

## Requirements
- R1: After reset, every control register reads 0x00, the programmable device address reads 0xEA, the acknowledge output is low, and no two-wire session is open.
- R2: A device-address strobe whose bits [7:1] equal 7'b1110101 (from 0xEA) raises `i2c_ack` in the next cycle. This holds whatever the value of bit 0 and whatever the programmable address is. In a cycle after a cycle with no strobe, `i2c_ack` is low.
- R3: A device-address strobe whose bits [7:1] equal bits [7:1] of the programmable address is also acknowledged. A strobe matching neither address gets no acknowledge and closes any open session.
- R4: Two-wire writes and reads take effect only while a session is open. A session opens on an acknowledged address strobe and closes on `i2c_stop` or on an unmatched address strobe. In the two-wire map the programmable address sits at 0xDE, the clear register at 0xE0, and the control registers at 0xE1 to 0xEB.
- R5: In the four-wire map the same registers sit at 0x5E, 0x60 and 0x61 to 0x6B. A value written through either map reads back through the other. Control register n appears on `ctrl_regs[8n+7:8n]`, where n is the address minus 0x61 (or minus 0xE1).
- R6: A write of any data to the clear register, from either path, sets all control registers to 0x00 in the next cycle. The programmable address is left unchanged, and the clear register always reads 0x00.
- R7: A clear write beats a control-register write made in the same cycle by the other path.
- R8: When both paths write the same register in the same cycle, the two-wire data is stored.
- R9: Test-select codes 0 to 4 make both test pins outputs (`tpin_oe` = 2'b11). For code k they drive `test_src[2k+1:2k]`. Code 5 makes them inputs (`tpin_oe` = 2'b00, `tpin_out` = 2'b00). Codes 6 and 7 drive 2'b00 as outputs.
- R10: Read data appears one cycle after the read strobe and returns the contents before any write made in that cycle. It is 0x00 in a cycle that follows no read, for an unmapped address, and for a two-wire read without a session. A two-wire address with bit 7 clear and a four-wire address with bit 7 set are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| i2c_dev_vld | input | 1 | Device-address byte strobe, two-wire path |
| i2c_dev_byte | input | 8 | Device-address byte (bit 0 is the transfer direction) |
| i2c_stop | input | 1 | End of two-wire transaction, closes the session |
| i2c_ack | output | 1 | Device acknowledge, one cycle after the strobe |
| i2c_wr_vld | input | 1 | Two-wire register write strobe |
| i2c_rd_vld | input | 1 | Two-wire register read strobe |
| i2c_addr | input | 8 | Two-wire register address |
| i2c_wdata | input | 8 | Two-wire write data |
| i2c_rdata | output | 8 | Two-wire read data |
| spi_wr_vld | input | 1 | Four-wire register write strobe |
| spi_rd_vld | input | 1 | Four-wire register read strobe |
| spi_addr | input | 8 | Four-wire register address |
| spi_wdata | input | 8 | Four-wire write data |
| spi_rdata | output | 8 | Four-wire read data |
| test_src | input | 10 | Five internal signal pairs offered to the test pins |
| tpin_oe | output | 2 | Test pin output enables |
| tpin_out | output | 2 | Test pin output values |
| ctrl_regs | output | 88 | All control registers, register n in bits [8n+7:8n] |

## Verification
The assertions expect every strobe to last one cycle, with no new device-address strobe in the cycle where the acknowledge for a previous strobe is checked. They also expect the programmable-address check after a four-wire clear to be made only in cycles without a two-wire write, because that write may legally change the programmable address. The bench keeps within these limits by driving each strobe for one cycle from a task, away from the clock edge, and by returning every strobe to zero before the next one. The only cycles where both paths are active together are the priority cases of R7 and R8, and those are driven deliberately.

// File: rtl/ctrlbank_pkg.sv
// Package: shared constants and the request type used by the register bank.
// Assumes: register indices are the low seven address bits of either map.
package ctrlbank_pkg;

    localparam int IDX_W = 7;
    localparam int DATA_W = 8;

    // Index positions shared by both maps (address with bit 7 removed).
    localparam logic [IDX_W-1:0] PROG_IDX = 7'h5E;
    localparam logic [IDX_W-1:0] CLR_IDX = 7'h60;
    localparam logic [IDX_W-1:0] CTRL_BASE = 7'h61;

    // Test-select field inside control register 0.
    localparam int TSEL_LSB = 0;
    localparam int TSEL_W = 3;

    // One decoded request from a host path.
    typedef struct packed {
        logic wr;
        logic rd;
        logic [IDX_W-1:0] idx;
        logic [DATA_W-1:0] data;
    } cb_req_t;

endpackage

// File: rtl/cb_dev_match.sv
// Module: device-address matcher for the two-wire path.
// Compares bits [7:1] of each address byte with a fixed address and a
// programmable one, acknowledges a hit one cycle later and keeps a
// session flag that gates register access.
// Assumes: strobes last one cycle; bit 0 of the byte is the direction bit.
module cb_dev_match #(
    parameter logic [7:0] FIXED_ADDR = 8'hEA
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dev_vld,
    input  logic [7:0] dev_byte,
    input  logic       stop,
    input  logic [7:0] prog_addr,
    output logic       ack,
    output logic       sel
);

    logic hit;
    logic unused_dir;

    assign unused_dir = dev_byte[0] ^ prog_addr[0];

    // Purpose: decide whether the byte belongs to this device.
    always_comb begin
        hit = (dev_byte[7:1] == FIXED_ADDR[7:1]) ||
              (dev_byte[7:1] == prog_addr[7:1]);
    end

    // Purpose: register the acknowledge and track the open session.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack <= 1'b0;
            sel <= 1'b0;
        end else if (dev_vld) begin
            ack <= hit;
            sel <= hit;
        end else begin
            ack <= 1'b0;
            if (stop) begin
                sel <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/cb_port_decode.sv
// Module: turns one host path's strobes into a request on the shared array.
// Keeps only addresses whose bit 7 equals MAP_HI and gates them with en.
// Assumes: write and read may be strobed together on one address.
module cb_port_decode
    import ctrlbank_pkg::*;
#(
    parameter bit MAP_HI = 1'b1
) (
    input  logic        wr_vld,
    input  logic        rd_vld,
    input  logic        en,
    input  logic [7:0]  addr,
    input  logic [7:0]  wdata,
    output cb_req_t     req
);

    logic in_map;

    // Purpose: qualify strobes with the map bit and the enable.
    always_comb begin
        in_map   = (addr[7] == MAP_HI) && en;
        req.wr   = wr_vld && in_map;
        req.rd   = rd_vld && in_map;
        req.idx  = addr[IDX_W-1:0];
        req.data = wdata;
    end

endmodule

// File: rtl/cb_reg_file.sv
// Module: the shared register array: programmable device address, the
// data-less clear register and N_CTRL control registers.
// Port A has priority over port B for the same register. A clear from either
// port beats any control-register write in that cycle.
// Assumes: requests are already map-checked; reads return pre-write contents.
module cb_reg_file
    import ctrlbank_pkg::*;
#(
    parameter int         N_CTRL   = 11,
    parameter logic [7:0] PROG_RST = 8'hEA
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  cb_req_t               req_a,
    input  cb_req_t               req_b,
    output logic [N_CTRL*8-1:0]   ctrl_flat,
    output logic [7:0]            prog_addr,
    output logic [7:0]            rdata_a,
    output logic [7:0]            rdata_b
);

    localparam int FLAT_W = N_CTRL * 8;

    logic clr;

    // Purpose: read mux over the whole map for one index.
    function automatic logic [7:0] peek(input logic [IDX_W-1:0] idx,
                                        input logic [FLAT_W-1:0] flat,
                                        input logic [7:0] prog);
        logic [7:0] v;
        v = 8'h00;
        if (idx == PROG_IDX) begin
            v = prog;
        end
        for (int k = 0; k < N_CTRL; k++) begin
            if (idx == IDX_W'(int'(CTRL_BASE) + k)) begin
                v = flat[k*8 +: 8];
            end
        end
        return v;
    endfunction

    // Purpose: detect a write to the clear register from either port.
    always_comb begin
        clr = (req_a.wr && (req_a.idx == CLR_IDX)) ||
              (req_b.wr && (req_b.idx == CLR_IDX));
    end

    // Purpose: programmable device address, untouched by the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_addr <= PROG_RST;
        end else if (req_a.wr && (req_a.idx == PROG_IDX)) begin
            prog_addr <= req_a.data;
        end else if (req_b.wr && (req_b.idx == PROG_IDX)) begin
            prog_addr <= req_b.data;
        end
    end

    // Purpose: control registers with clear and port priority.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ctrl_flat <= '0;
        end else begin
            for (int k = 0; k < N_CTRL; k++) begin
                if (req_a.wr && (req_a.idx == IDX_W'(int'(CTRL_BASE) + k))) begin
                    ctrl_flat[k*8 +: 8] <= req_a.data;
                end else if (req_b.wr && (req_b.idx == IDX_W'(int'(CTRL_BASE) + k))) begin
                    ctrl_flat[k*8 +: 8] <= req_b.data;
                end
            end
        end
    end

    // Purpose: registered read data per port, zero when no read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_a <= 8'h00;
            rdata_b <= 8'h00;
        end else begin
            rdata_a <= req_a.rd ? peek(req_a.idx, ctrl_flat, prog_addr) : 8'h00;
            rdata_b <= req_b.rd ? peek(req_b.idx, ctrl_flat, prog_addr) : 8'h00;
        end
    end

endmodule

// File: rtl/cb_test_mux.sv
// Module: test pin direction and source selection from the test-select code.
// Codes below N_SRC drive a source pair, code N_SRC turns the pins to inputs,
// higher codes drive zero.
// Assumes: purely combinational, the code comes straight from a register.
module cb_test_mux #(
    parameter int N_SRC  = 5,
    parameter int TSEL_W = 3
) (
    input  logic [TSEL_W-1:0]  tsel,
    input  logic [N_SRC*2-1:0] src,
    output logic [1:0]         oe,
    output logic [1:0]         out
);

    // Purpose: choose pin direction and the driven pair.
    always_comb begin
        oe  = 2'b11;
        out = 2'b00;
        if (int'(tsel) < N_SRC) begin
            for (int k = 0; k < N_SRC; k++) begin
                if (int'(tsel) == k) begin
                    out = src[k*2 +: 2];
                end
            end
        end else if (int'(tsel) == N_SRC) begin
            oe = 2'b00;
        end
    end

endmodule

// File: rtl/ctrlbank_top.sv
// Module: top of the dual-address control register bank.
// Connects the device-address matcher, one decoder per host path, the shared
// register array and the test pin mux.
// Assumes: the serial engines deliver one-cycle byte strobes; the two-wire
// path is port A (wins ties), the four-wire path is port B.
module ctrlbank_top
    import ctrlbank_pkg::*;
#(
    parameter int         N_CTRL     = 11,
    parameter int         N_SRC      = 5,
    parameter logic [7:0] FIXED_ADDR = 8'hEA
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 i2c_dev_vld,
    input  logic [7:0]           i2c_dev_byte,
    input  logic                 i2c_stop,
    output logic                 i2c_ack,
    input  logic                 i2c_wr_vld,
    input  logic                 i2c_rd_vld,
    input  logic [7:0]           i2c_addr,
    input  logic [7:0]           i2c_wdata,
    output logic [7:0]           i2c_rdata,
    input  logic                 spi_wr_vld,
    input  logic                 spi_rd_vld,
    input  logic [7:0]           spi_addr,
    input  logic [7:0]           spi_wdata,
    output logic [7:0]           spi_rdata,
    input  logic [N_SRC*2-1:0]   test_src,
    output logic [1:0]           tpin_oe,
    output logic [1:0]           tpin_out,
    output logic [N_CTRL*8-1:0]  ctrl_regs
);

    logic       i2c_sel;
    logic [7:0] prog_addr;
    cb_req_t    req_i2c;
    cb_req_t    req_spi;

    cb_dev_match #(.FIXED_ADDR(FIXED_ADDR)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .dev_vld   (i2c_dev_vld),
        .dev_byte  (i2c_dev_byte),
        .stop      (i2c_stop),
        .prog_addr (prog_addr),
        .ack       (i2c_ack),
        .sel       (i2c_sel)
    );

    cb_port_decode #(.MAP_HI(1'b1)) u_dec_i2c (
        .wr_vld (i2c_wr_vld),
        .rd_vld (i2c_rd_vld),
        .en     (i2c_sel),
        .addr   (i2c_addr),
        .wdata  (i2c_wdata),
        .req    (req_i2c)
    );

    cb_port_decode #(.MAP_HI(1'b0)) u_dec_spi (
        .wr_vld (spi_wr_vld),
        .rd_vld (spi_rd_vld),
        .en     (1'b1),
        .addr   (spi_addr),
        .wdata  (spi_wdata),
        .req    (req_spi)
    );

    cb_reg_file #(.N_CTRL(N_CTRL), .PROG_RST(FIXED_ADDR)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_a     (req_i2c),
        .req_b     (req_spi),
        .ctrl_flat (ctrl_regs),
        .prog_addr (prog_addr),
        .rdata_a   (i2c_rdata),
        .rdata_b   (spi_rdata)
    );

    cb_test_mux #(.N_SRC(N_SRC), .TSEL_W(TSEL_W)) u_tmux (
        .tsel (ctrl_regs[TSEL_LSB +: TSEL_W]),
        .src  (test_src),
        .oe   (tpin_oe),
        .out  (tpin_out)
    );

endmodule

// File: rtl/ctrlbank_chk.sv
// Module: assertion checker bound to ctrlbank_top.
// Assumes: default parameters (0xEA fixed address, clear at 0x60/0xE0).
module ctrlbank_chk #(
    parameter int N_CTRL = 11
) (
    input logic                clk,
    input logic                rst_n,
    input logic                i2c_dev_vld,
    input logic [7:0]          i2c_dev_byte,
    input logic                i2c_ack,
    input logic                i2c_sel,
    input logic                i2c_wr_vld,
    input logic [7:0]          i2c_addr,
    input logic                spi_wr_vld,
    input logic                spi_rd_vld,
    input logic [7:0]          spi_addr,
    input logic [7:0]          spi_rdata,
    input logic [N_CTRL*8-1:0] ctrl_regs,
    input logic [7:0]          prog_addr,
    input logic [1:0]          tpin_oe
);

    AST_ACK_ON_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        i2c_dev_vld && (i2c_dev_byte inside {8'hEA, 8'hEB}) |=> i2c_ack); // R2
    AST_ACK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !i2c_dev_vld |=> !i2c_ack); // R2
    AST_ACK_SESSION: assert property (@(posedge clk) disable iff (!rst_n)
        i2c_dev_vld |=> (i2c_ack == i2c_sel)); // R3
    AST_SPI_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        spi_wr_vld && (spi_addr == 8'h60) |=> (ctrl_regs == '0)); // R6
    AST_I2C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        i2c_sel && i2c_wr_vld && (i2c_addr == 8'hE0) |=> (ctrl_regs == '0)); // R7
    AST_PROG_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        spi_wr_vld && (spi_addr == 8'h60) && !i2c_wr_vld |=> $stable(prog_addr)); // R6
    AST_TPIN_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_regs[2:0] == 3'd5) |-> (tpin_oe == 2'b00)); // R9
    AST_TPIN_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_regs[2:0] != 3'd5) |-> (tpin_oe == 2'b11)); // R9
    AST_SPI_HIGH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        spi_wr_vld && spi_addr[7] && !i2c_wr_vld |=> $stable(ctrl_regs)); // R10
    AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_rd_vld |=> (spi_rdata == 8'h00)); // R10

endmodule

bind ctrlbank_top ctrlbank_chk #(.N_CTRL(N_CTRL)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .i2c_dev_vld  (i2c_dev_vld),
    .i2c_dev_byte (i2c_dev_byte),
    .i2c_ack      (i2c_ack),
    .i2c_sel      (i2c_sel),
    .i2c_wr_vld   (i2c_wr_vld),
    .i2c_addr     (i2c_addr),
    .spi_wr_vld   (spi_wr_vld),
    .spi_rd_vld   (spi_rd_vld),
    .spi_addr     (spi_addr),
    .spi_rdata    (spi_rdata),
    .ctrl_regs    (ctrl_regs),
    .prog_addr    (prog_addr),
    .tpin_oe      (tpin_oe)
);

// File: tb/ctrlbank_top_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module ctrlbank_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        i2c_dev_vld = 1'b0;
    logic [7:0]  i2c_dev_byte = 8'h00;
    logic        i2c_stop = 1'b0;
    logic        i2c_ack;
    logic        i2c_wr_vld = 1'b0;
    logic        i2c_rd_vld = 1'b0;
    logic [7:0]  i2c_addr = 8'h00;
    logic [7:0]  i2c_wdata = 8'h00;
    logic [7:0]  i2c_rdata;
    logic        spi_wr_vld = 1'b0;
    logic        spi_rd_vld = 1'b0;
    logic [7:0]  spi_addr = 8'h00;
    logic [7:0]  spi_wdata = 8'h00;
    logic [7:0]  spi_rdata;
    logic [9:0]  test_src = 10'b00_11_10_01_11;
    logic [1:0]  tpin_oe;
    logic [1:0]  tpin_out;
    logic [87:0] ctrl_regs;

    int n_checks = 0;
    int n_fails = 0;

    always #5 clk = ~clk;

    ctrlbank_top u_dut (
        .clk(clk), .rst_n(rst_n),
        .i2c_dev_vld(i2c_dev_vld), .i2c_dev_byte(i2c_dev_byte),
        .i2c_stop(i2c_stop), .i2c_ack(i2c_ack),
        .i2c_wr_vld(i2c_wr_vld), .i2c_rd_vld(i2c_rd_vld),
        .i2c_addr(i2c_addr), .i2c_wdata(i2c_wdata), .i2c_rdata(i2c_rdata),
        .spi_wr_vld(spi_wr_vld), .spi_rd_vld(spi_rd_vld),
        .spi_addr(spi_addr), .spi_wdata(spi_wdata), .spi_rdata(spi_rdata),
        .test_src(test_src), .tpin_oe(tpin_oe), .tpin_out(tpin_out),
        .ctrl_regs(ctrl_regs)
    );

    task automatic check(input string req, input logic [87:0] act, input logic [87:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic dev(input logic [7:0] b, output logic a);
        @(negedge clk); i2c_dev_vld = 1'b1; i2c_dev_byte = b;
        @(negedge clk); i2c_dev_vld = 1'b0; a = i2c_ack;
    endtask

    task automatic i2c_wr(input logic [7:0] ad, input logic [7:0] d);
        @(negedge clk); i2c_wr_vld = 1'b1; i2c_addr = ad; i2c_wdata = d;
        @(negedge clk); i2c_wr_vld = 1'b0;
    endtask

    task automatic spi_wr(input logic [7:0] ad, input logic [7:0] d);
        @(negedge clk); spi_wr_vld = 1'b1; spi_addr = ad; spi_wdata = d;
        @(negedge clk); spi_wr_vld = 1'b0;
    endtask

    task automatic both_wr(input logic [7:0] ia, input logic [7:0] id,
                           input logic [7:0] sa, input logic [7:0] sd);
        @(negedge clk);
        i2c_wr_vld = 1'b1; i2c_addr = ia; i2c_wdata = id;
        spi_wr_vld = 1'b1; spi_addr = sa; spi_wdata = sd;
        @(negedge clk); i2c_wr_vld = 1'b0; spi_wr_vld = 1'b0;
    endtask

    task automatic i2c_rd(input logic [7:0] ad, output logic [7:0] d);
        @(negedge clk); i2c_rd_vld = 1'b1; i2c_addr = ad;
        @(negedge clk); i2c_rd_vld = 1'b0; d = i2c_rdata;
    endtask

    task automatic spi_rd(input logic [7:0] ad, output logic [7:0] d);
        @(negedge clk); spi_rd_vld = 1'b1; spi_addr = ad;
        @(negedge clk); spi_rd_vld = 1'b0; d = spi_rdata;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1 ack", 88'(i2c_ack), 88'(0));
        check("R1 ctrl", ctrl_regs, 88'(0));
        spi_rd(8'h5E, d); check("R1 prog", 88'(d), 88'hEA);
        i2c_wr(8'hE2, 8'h99);
        check("R1 no session", ctrl_regs, 88'(0));
    endtask

    task automatic t_fixed();
        logic a; logic [7:0] d;
        dev(8'hEA, a); check("R2 fixed write", 88'(a), 88'(1));
        dev(8'hEB, a); check("R2 fixed read dir", 88'(a), 88'(1));
        dev(8'h10, a); check("R3 miss", 88'(a), 88'(0));
        i2c_wr(8'hE2, 8'h5A);
        spi_rd(8'h62, d); check("R4 closed by miss", 88'(d), 88'(0));
    endtask

    task automatic t_prog();
        logic a; logic [7:0] d;
        spi_wr(8'h5E, 8'h40);
        dev(8'h40, a); check("R3 prog", 88'(a), 88'(1));
        dev(8'h41, a); check("R3 prog dir", 88'(a), 88'(1));
        dev(8'hEA, a); check("R2 fixed still", 88'(a), 88'(1));
        dev(8'h50, a); check("R3 other", 88'(a), 88'(0));
        i2c_rd(8'hDE, d); check("R10 read no session", 88'(d), 88'(0));
    endtask

    task automatic t_maps();
        logic a; logic [7:0] d;
        dev(8'hEA, a);
        i2c_wr(8'hE5, 8'h3C);
        spi_rd(8'h65, d); check("R5 i2c->spi", 88'(d), 88'h3C);
        check("R5 ctrl slot", 88'(ctrl_regs[4*8 +: 8]), 88'h3C);
        spi_wr(8'h6B, 8'h77);
        i2c_rd(8'hEB, d); check("R5 spi->i2c", 88'(d), 88'h77);
        i2c_rd(8'hDE, d); check("R4 prog via i2c", 88'(d), 88'h40);
        i2c_wr(8'h65, 8'h11);
        spi_rd(8'h65, d); check("R10 i2c low ignored", 88'(d), 88'h3C);
        spi_wr(8'hE5, 8'h22);
        i2c_rd(8'hE5, d); check("R10 spi high ignored", 88'(d), 88'h3C);
        spi_rd(8'h70, d); check("R10 unmapped", 88'(d), 88'(0));
        @(negedge clk); check("R10 idle rdata", 88'(spi_rdata), 88'(0));
        i2c_stop = 1'b1; @(negedge clk); i2c_stop = 1'b0;
        i2c_wr(8'hE5, 8'h66);
        check("R4 stop closes", 88'(ctrl_regs[4*8 +: 8]), 88'h3C);
    endtask

    task automatic t_clear();
        logic a; logic [7:0] d;
        dev(8'h40, a);
        i2c_wr(8'hE3, 8'hF0);
        i2c_wr(8'hE0, 8'h00);
        check("R6 i2c clear", ctrl_regs, 88'(0));
        spi_rd(8'h5E, d); check("R6 prog kept", 88'(d), 88'h40);
        spi_rd(8'h60, d); check("R6 clear reads 0", 88'(d), 88'(0));
        spi_wr(8'h67, 8'h81);
        spi_wr(8'h60, 8'hFF);
        check("R6 spi clear", ctrl_regs, 88'(0));
    endtask

    task automatic t_prio();
        logic [7:0] d;
        both_wr(8'hE3, 8'hAA, 8'h63, 8'h55);
        spi_rd(8'h63, d); check("R8 i2c wins", 88'(d), 88'hAA);
        both_wr(8'hE4, 8'h11, 8'h60, 8'h00);
        check("R7 clear wins", ctrl_regs, 88'(0));
    endtask

    task automatic t_tpin();
        for (int c = 0; c < 8; c++) begin
            spi_wr(8'h61, 8'(c));
            if (c < 5) begin
                check("R9 oe drive", 88'(tpin_oe), 88'(2'b11));
                check("R9 pair", 88'(tpin_out), 88'(test_src[c*2 +: 2]));
            end else if (c == 5) begin
                check("R9 oe input", 88'(tpin_oe), 88'(2'b00));
                check("R9 out input", 88'(tpin_out), 88'(0));
            end else begin
                check("R9 oe high codes", 88'(tpin_oe), 88'(2'b11));
                check("R9 zero high codes", 88'(tpin_out), 88'(0));
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fixed();
        t_prog();
        t_maps();
        t_clear();
        t_prio();
        t_tpin();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule